// File: doc/BRIEF.md
# Linked-List Memory-to-Stream Transmit Engine

This block drains memory buffers into a byte stream by walking a chain of data descriptors. A one-cycle `start` pulse hands it the address of the first data descriptor and the address of the context descriptor that owns the chain. Each data descriptor is four 32-bit words: the next pointer (offset 0), the buffer start address (offset 4), a flag word (offset 8) and the end address of the buffer (offset 12). The end address is exclusive. The transfer length is therefore the end address minus the current position, and no byte count is stored.

The engine fetches aligned words through a simple request/acknowledge memory port and sends the in-range bytes on a valid/ready stream. It sends at most `MAX_BURST` bytes in one burst. When a buffer is complete, the engine can pulse a data interrupt. It then writes the descriptor back. After that it either loads the next descriptor or, at end of list, sets the disable bit in the context descriptor and stops.

The controller has nine states, in `dtx_state_e`:

- `S_IDLE` waits for `start`, then goes to `S_LOAD`.
- `S_LOAD` reads the four descriptor words, then goes to `S_BURST`.
- `S_BURST` restarts the burst count. It goes to `S_FINISH` when the position equals the end address, and otherwise to `S_FETCH`.
- `S_FETCH` reads the word that holds the current byte, then goes to `S_SEND`.
- `S_SEND` offers one byte per handshake. It goes to `S_FINISH` on the final byte, to `S_BURST` when the burst limit is reached, and to `S_FETCH` at a word boundary.
- `S_FINISH` pulses the interrupt. It goes to `S_CTX_RD` at end of list, and otherwise to `S_STORE`.
- `S_CTX_RD` reads the context flag word, then goes to `S_CTX_WR`.
- `S_CTX_WR` writes the flag word back with the disable bit set, then goes to `S_STORE`.
- `S_STORE` writes the four descriptor words back. It then goes to `S_IDLE` if the list has ended, and otherwise to `S_LOAD` at the next pointer.

Top module: `dma_tx_chain`

## Requirements
- R1: After reset the engine is idle. `busy`, `tx_valid`, `mem_req`, `irq_data` and `eol_seen` are all low.
- R2: After `start`, the engine reads the descriptor words at the descriptor address plus 0, 4, 8 and 12, in that order. These words are next pointer, buffer start, flags and end address.
- R3: The engine sends every byte from the buffer start up to the end address minus one, in ascending address order, and no other byte. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the aligned word. All memory addresses are word-aligned.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values. While `mem_req` is high and `mem_ack` is low, the memory request holds its value.
- R5: `tx_last` is high on the final byte of a buffer exactly when flag bit 3 is set.
- R6: When a buffer completes and flag bit 4 is set, `irq_data` is high for one cycle. Otherwise it stays low.
- R7: When flag bit 0 is clear, the engine loads the next descriptor from the next pointer and continues from that descriptor's buffer start.
- R8: When flag bit 0 is set, the engine reads the context word at the context address plus 4 and writes it back with bit 15 set. It then sets `eol_seen` and returns to idle. A new `start` clears `eol_seen`.
- R9: The engine writes the four words of a completed descriptor back, unchanged, to the descriptor's own address. On the end-of-list path this happens after the context write.
- R10: After every `MAX_BURST` bytes the engine starts a new burst. The new burst refetches the word that holds the next byte.
- R11: A descriptor whose buffer start equals its end address sends no bytes. It is still completed, written back and chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking a chain (accepted only while idle) |
| desc_addr | input | AW | Address of the first data descriptor |
| ctx_addr | input | AW | Address of the owning context descriptor |
| busy | output | 1 | Engine is not idle |
| eol_seen | output | 1 | The last chain ended at an end-of-list descriptor |
| irq_data | output | 1 | One-cycle pulse for a completed buffer with the interrupt flag set |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted (read data valid in the same cycle) |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a buffer with output end-of-packet set |
| tx_ready | input | 1 | Stream sink accepts the byte |

## Verification
The bench starts a buffer at an odd byte offset and ends it mid-word. A design that does not trim partial words would send stray leading or trailing bytes, and the scoreboard would see them. A chain that includes a zero-length descriptor tests the completion path. A design that fetches data for an empty buffer, or that skips its write-back, would show extra reads or a missing descriptor write. The bench also checks the order of the context write and the descriptor write-back, and checks that only the final descriptor's context gets bit 15. A small burst limit should produce exactly one word refetch per burst boundary. A design that ignores the limit shows fewer data reads, and one that mishandles it drops or repeats bytes.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_BURST, S_FETCH, S_SEND,
        S_FINISH, S_CTX_RD, S_CTX_WR, S_STORE
    } dtx_state_e;

    localparam int FL_EOL  = 0;   // end of list
    localparam int FL_OEOP = 3;   // mark last byte of buffer
    localparam int FL_INTR = 4;   // data interrupt on completion
    localparam int CTX_DIS = 15;  // disable bit in context flag word
endpackage

// File: rtl/dtx_byte_lane.sv
module dtx_byte_lane #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0]        word,
    input  logic [$clog2(NBYTES)-1:0]  lane,
    output logic [7:0]                 byte_o
);
    logic [7:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/dtx_burst_ctr.sv
module dtx_burst_ctr #(
    parameter int MAX_BURST = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_lim
);
    localparam int CW = $clog2(MAX_BURST) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign at_lim = (cnt == CW'(MAX_BURST - 1));
endmodule

// File: rtl/dma_tx_chain.sv
module dma_tx_chain
    import dtx_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_BURST = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] desc_addr,
    input  logic [AW-1:0] ctx_addr,
    output logic          busy,
    output logic          eol_seen,
    output logic          irq_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready
);
    localparam int NBYTES = 4;
    localparam int LW     = $clog2(NBYTES);
    localparam logic [AW-1:0] CTX_FLAG_OFS = AW'(4);

    dtx_state_e state_q, state_d;

    logic [1:0]    widx;
    logic [AW-1:0] cur_addr, ctx_q, pos;
    logic [31:0]   d_next, d_buf, d_flags, d_end, word_q, ctx_word;
    logic          eol_q;
    logic          at_lim, last_byte;
    logic [AW-1:0] slot_addr;
    logic [31:0]   slot_data;

    assign last_byte = (pos + 1'b1) == d_end[AW-1:0];
    assign slot_addr = cur_addr + AW'({widx, 2'b00});

    always_comb begin
        unique case (widx)
            2'd0: slot_data = d_next;
            2'd1: slot_data = d_buf;
            2'd2: slot_data = d_flags;
            default: slot_data = d_end;
        endcase
    end

    dtx_byte_lane #(.NBYTES(NBYTES)) u_lane (
        .word(word_q), .lane(pos[LW-1:0]), .byte_o(tx_data)
    );

    dtx_burst_ctr #(.MAX_BURST(MAX_BURST)) u_bctr (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == S_BURST),
        .inc(state_q == S_SEND && tx_ready),
        .at_lim(at_lim)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_LOAD;
            S_LOAD:   if (mem_ack && widx == 2'd3) state_d = S_BURST;
            S_BURST:  state_d = (pos == d_end[AW-1:0]) ? S_FINISH : S_FETCH;
            S_FETCH:  if (mem_ack) state_d = S_SEND;
            S_SEND:
                if (tx_ready) begin
                    if (last_byte)                  state_d = S_FINISH;
                    else if (at_lim)                state_d = S_BURST;
                    else if (&pos[LW-1:0])          state_d = S_FETCH;
                end
            S_FINISH: state_d = d_flags[FL_EOL] ? S_CTX_RD : S_STORE;
            S_CTX_RD: if (mem_ack) state_d = S_CTX_WR;
            S_CTX_WR: if (mem_ack) state_d = S_STORE;
            S_STORE:
                if (mem_ack && widx == 2'd3)
                    state_d = eol_q ? S_IDLE : S_LOAD;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        irq_data  = 1'b0;
        unique case (state_q)
            S_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {pos[AW-1:LW], {LW{1'b0}}};
            end
            S_SEND: begin
                tx_valid = 1'b1;
                tx_last  = d_flags[FL_OEOP] && last_byte;
            end
            S_FINISH: irq_data = d_flags[FL_INTR];
            S_CTX_RD: begin
                mem_req  = 1'b1;
                mem_addr = ctx_q + CTX_FLAG_OFS;
            end
            S_CTX_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q + CTX_FLAG_OFS;
                mem_wdata = ctx_word;
            end
            S_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_addr;
                mem_wdata = slot_data;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign eol_seen = eol_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx     <= '0;
            cur_addr <= '0;
            ctx_q    <= '0;
            pos      <= '0;
            d_next   <= '0;
            d_buf    <= '0;
            d_flags  <= '0;
            d_end    <= '0;
            word_q   <= '0;
            ctx_word <= '0;
            eol_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE:
                    if (start) begin
                        cur_addr <= desc_addr;
                        ctx_q    <= ctx_addr;
                        eol_q    <= 1'b0;
                        widx     <= '0;
                    end
                S_LOAD:
                    if (mem_ack) begin
                        unique case (widx)
                            2'd0: d_next  <= mem_rdata;
                            2'd1: d_buf   <= mem_rdata;
                            2'd2: d_flags <= mem_rdata;
                            default: begin
                                d_end <= mem_rdata;
                                pos   <= d_buf[AW-1:0];
                            end
                        endcase
                        widx <= widx + 1'b1;
                    end
                S_FETCH:  if (mem_ack) word_q <= mem_rdata;
                S_SEND:   if (tx_ready) pos <= pos + 1'b1;
                S_FINISH: begin
                    widx <= '0;
                    if (d_flags[FL_EOL]) eol_q <= 1'b1;
                end
                S_CTX_RD:
                    if (mem_ack) ctx_word <= mem_rdata | (32'd1 << CTX_DIS);
                S_STORE:
                    if (mem_ack) begin
                        widx <= widx + 1'b1;
                        if (widx == 2'd3 && !eol_q) cur_addr <= d_next[AW-1:0];
                    end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_tx_chain_chk.sv
module dma_tx_chain_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          eol_seen,
    input logic          irq_data,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R4
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R3
    AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_data |=> !irq_data); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid && !mem_req && !irq_data); // R1
    AST_NO_TX_AFTER_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        eol_seen |-> !tx_valid); // R8
endmodule

bind dma_tx_chain dma_tx_chain_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .eol_seen(eol_seen),
    .irq_data(irq_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready)
);

// File: tb/tb_dma_tx_chain.sv
module tb_dma_tx_chain;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] desc_addr = '0, ctx_addr = '0;
    logic busy, eol_seen, irq_data, mem_req, mem_we, tx_valid, tx_last;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic mem_ack = 1'b0, tx_ready = 1'b0;
    logic [7:0] tx_data;

    always #10 clk = ~clk;

    dma_tx_chain #(.AW(AW), .MAX_BURST(3)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_addr(desc_addr),
        .ctx_addr(ctx_addr), .busy(busy), .eol_seen(eol_seen),
        .irq_data(irq_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready)
    );

    logic [31:0] mem [0:511];
    logic [8:0]  exp_q [$];
    logic [31:0] rd_log [$];
    logic [31:0] wr_log [$];
    int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
    logic prev_stall = 1'b0;
    logic [8:0] prev_beat = '0;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model, stream sink, scoreboard monitor, watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (prev_stall) check(tx_valid && {tx_last, tx_data} == prev_beat, "R4",
                              {tx_valid, tx_last, tx_data}, {2'b1, prev_beat});
        tx_ready = (cyc % 5) != 2;
        prev_stall = tx_valid && !tx_ready;
        prev_beat = {tx_last, tx_data};
        if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) check(1'b0, "R3", {tx_last, tx_data}, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(tx_data == e[7:0], "R3", tx_data, e[7:0]);
                check(tx_last == e[8], "R5", tx_last, e[8]);
            end
        end
        if (irq_data) irq_cnt++;
        mem_ack = mem_req && ((cyc % 3) != 1);
        mem_rdata = mem[mem_addr[10:2]];
        if (mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[10:2]] = mem_wdata;
                wr_log.push_back(mem_addr);
            end else rd_log.push_back(mem_addr);
        end
    end

    task automatic put_desc(input int a, input int nxt, input int b, input int fl,
                            input int e);
        mem[a/4] = nxt; mem[a/4+1] = b; mem[a/4+2] = fl; mem[a/4+3] = e;
        for (int x = b; x < e; x++)
            exp_q.push_back({fl[3] && (x == e - 1), pat(x)});
    endtask

    task automatic run(input int d, input int c);
        rd_log.delete(); wr_log.delete(); irq_cnt = 0;
        @(negedge clk);
        desc_addr = d; ctx_addr = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !eol_seen, "R8", {busy, eol_seen}, 2'b10);
        while (busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++)
            mem[i] = {pat(i*4+3), pat(i*4+2), pat(i*4+1), pat(i*4)};
        repeat (4) @(negedge clk);
        check(!busy && !tx_valid && !mem_req && !irq_data && !eol_seen, "R1",
              {busy, tx_valid, mem_req, irq_data, eol_seen}, 0);
        rst_n = 1'b1;

        // T1: unaligned single buffer, eol + last + interrupt
        mem[32'h784/4] = 32'h3;
        put_desc(32'h100, 32'h0, 32'h402, 32'h19, 32'h40B);
        run(32'h100, 32'h780);
        for (int k = 0; k < 4; k++)
            check(rd_log[k] == 32'h100 + 4*k, "R2", rd_log[k], 32'h100 + 4*k);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        check(irq_cnt == 1, "R6", irq_cnt, 1);
        check(eol_seen && !busy, "R8", {eol_seen, busy}, 2'b10);
        check(mem[32'h784/4] == 32'h8003, "R8", mem[32'h784/4], 32'h8003);
        check(wr_log.size() == 5 && wr_log[0] == 32'h784, "R9", wr_log[0], 32'h784);
        check(wr_log[4] == 32'h10C && mem[32'h108/4] == 32'h19, "R9", mem[32'h108/4], 32'h19);

        // T2: chain A -> B (empty) -> C (eol)
        mem[32'h7A4/4] = 32'h0;
        put_desc(32'h200, 32'h300, 32'h500, 32'h10, 32'h50A);
        put_desc(32'h300, 32'h340, 32'h520, 32'h00, 32'h520);
        put_desc(32'h340, 32'h0, 32'h531, 32'h09, 32'h534);
        run(32'h200, 32'h7A0);
        begin
            logic [31:0] dr [$];
            foreach (rd_log[k]) if (rd_log[k] < 32'h400) dr.push_back(rd_log[k]);
            check(dr.size() == 12, "R7", dr.size(), 12);
            if (dr.size() == 12) begin
                check(dr[4] == 32'h300, "R7", dr[4], 32'h300);
                check(dr[8] == 32'h340, "R7", dr[8], 32'h340);
            end
            foreach (rd_log[k])
                if (rd_log[k] >= 32'h520 && rd_log[k] < 32'h530)
                    check(1'b0, "R11", rd_log[k], 0);
        end
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        check(irq_cnt == 1, "R6", irq_cnt, 1);
        check(wr_log.size() == 13, "R11", wr_log.size(), 13);
        if (wr_log.size() == 13) begin
            check(wr_log[4] == 32'h300, "R11", wr_log[4], 32'h300);
            check(wr_log[8] == 32'h7A4, "R9", wr_log[8], 32'h7A4);
        end
        check(mem[32'h7A4/4] == 32'h8000, "R8", mem[32'h7A4/4], 32'h8000);

        // T3: burst limit 3 on aligned 10-byte buffer -> 6 data word reads
        put_desc(32'h180, 32'h0, 32'h600, 32'h01, 32'h60A);
        run(32'h180, 32'h780);
        begin
            int n = 0;
            foreach (rd_log[k]) if (rd_log[k] >= 32'h400 && rd_log[k] < 32'h780) n++;
            check(n == 6, "R10", n, 6);
        end
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);
        check(irq_cnt == 0, "R6", irq_cnt, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule